// File: doc/BRIEF.md
# Deadline Timer Channel

This block is one timer channel that watches a 64-bit free-running count supplied from outside. Software programs a deadline in either of two coupled views: an absolute 64-bit compare value, or a relative 32-bit signed value meaning "this many ticks from now". Both views describe the same stored compare register, so writing one changes what the other reads back. When the timer is enabled and the deadline has been reached, a status flag sets. The level interrupt output follows that flag unless the mask bit is set.

When `HAS_OFFSET` is 1, the channel subtracts a 64-bit offset input from the count before any comparison or relative calculation. This lets the same channel serve as a virtual timer. When `HAS_OFFSET` is 0, the offset input is ignored and the count is used directly. Several instances can sit side by side to serve separate physical, secure, hypervisor and virtual timers.

Register access uses a valid/ready request channel and a valid/ready read-response channel:
- A request is taken on a clock edge where `req_valid` and `req_ready` are both high.
- Each accepted read produces exactly one response. Writes produce no response.
- The response holds `rsp_valid` and `rsp_rdata` steady until `rsp_ready` is high.
- While an untaken response is pending, `req_ready` is low. This back-pressures the request side.

Top module: `tmr_channel`

## Requirements
- R1: After reset, `irq_o` is 0, and the control word, compare low and compare high all read as 0.
- R2: Address 0 writes/reads compare bits [31:0], and address 1 writes/reads compare bits [63:32]. The compare register changes only on an accepted write to address 0, 1 or 2.
- R3: The effective count is `count_i - offset_i` (64-bit wrap). The deadline condition is unsigned (effective count >= compare), which includes equality. Control read bit 2 (status) equals enable AND condition.
- R4: On each clock edge, `irq_o` is loaded with enable AND condition AND NOT mask, using the register and count values present before that edge. It therefore drops on the edge after a new compare value makes the condition false.
- R5: An accepted write to address 2 (timer value) sets compare to effective count + the sign-extended 32-bit write data, using the effective count at the accepting edge.
- R6: A read of address 2 returns the low 32 bits of (compare − effective count). Past the deadline this reads as a negative two's-complement number.
- R7: With `HAS_OFFSET`=1 (the default), changing `offset_i` shifts the condition and the timer-value read by the offset.
- R8: Control address 3 has these bits:
  - bit 0: enable, read/write.
  - bit 1: mask, read/write.
  - bit 2: status, read-only. Writing to it has no effect.
  - bits [31:3]: read as 0.
- R9: A read request is accepted when `req_valid` and `req_ready` are both high. The response appears with `rsp_valid` on the accepting edge. It holds `rsp_rdata` stable while `rsp_ready` is low, and during that time `req_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| count_i | input | 64 | Free-running count |
| offset_i | input | 64 | Offset subtracted from the count when enabled by parameter |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Register request ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2 | 0 compare low, 1 compare high, 2 timer value, 3 control |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response ready |
| rsp_rdata | output | 32 | Read data |
| irq_o | output | 1 | Level interrupt |

## Verification
Embedded properties check the following on every cycle:
- The interrupt is never high after a cycle with enable low or mask high.
- The compare register holds its value unless one of its writing addresses is accepted.
- A stalled response keeps its data, and the request channel stays blocked while it does.

Only the bench scenarios can show the numeric results:
- Equality firing exactly at the deadline.
- A relative write computing the right absolute deadline.
- A timer-value read turning negative past the deadline.
- The offset shifting both views.
- The interrupt falling on the edge after a compare rewrite.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    SEL_CMP_LO = 2'd0,
    SEL_CMP_HI = 2'd1,
    SEL_TVAL   = 2'd2,
    SEL_CTRL   = 2'd3
  } tmr_sel_e;

  localparam int unsigned CTL_EN_BIT   = 0;
  localparam int unsigned CTL_MASK_BIT = 1;
  localparam int unsigned CTL_STAT_BIT = 2;
endpackage

// File: rtl/tmr_match.sv
module tmr_match #(
  parameter int unsigned CNT_W      = 64,
  parameter int unsigned TV_W       = 32,
  parameter bit          HAS_OFFSET = 1'b1
) (
  input  logic [CNT_W-1:0] count_i,
  input  logic [CNT_W-1:0] offset_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic [CNT_W-1:0] eff_o,
  output logic             cond_o,
  output logic [TV_W-1:0]  tv_o
);
  logic [CNT_W-1:0] remain;

  generate
    if (HAS_OFFSET) begin : g_off
      assign eff_o = count_i - offset_i;
    end else begin : g_nooff
      logic unused_offset;
      assign unused_offset = ^offset_i;
      assign eff_o = count_i;
    end
  endgenerate

  // deadline reached: unsigned effective count at or past compare
  assign cond_o = (eff_o >= cmp_i);
  assign remain = cmp_i - eff_o;
  assign tv_o   = remain[TV_W-1:0];
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 64,
  parameter int unsigned DW    = 32,
  parameter int unsigned TV_W  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [1:0]       req_addr,
  input  logic [DW-1:0]    req_wdata,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [DW-1:0]    rsp_rdata,
  input  logic [CNT_W-1:0] eff_i,
  input  logic             cond_i,
  input  logic [TV_W-1:0]  tv_i,
  output logic [CNT_W-1:0] cmp_o,
  output logic             en_o,
  output logic             mask_o
);
  localparam int unsigned EXT_W = CNT_W - TV_W;
  localparam int unsigned HI_W  = CNT_W - DW;

  logic [CNT_W-1:0] cmp_q;
  logic             en_q, mask_q;
  logic             rsp_v_q;
  logic [DW-1:0]    rsp_d_q;
  logic             accept;
  logic [DW-1:0]    rd_mux;
  logic [CNT_W-1:0] tv_wr_val;
  tmr_sel_e         sel;

  assign sel       = tmr_sel_e'(req_addr);
  assign req_ready = !rsp_v_q || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign tv_wr_val = eff_i + {{EXT_W{req_wdata[TV_W-1]}}, req_wdata[TV_W-1:0]};

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_CMP_LO: rd_mux = cmp_q[DW-1:0];
      SEL_CMP_HI: rd_mux = DW'(cmp_q[CNT_W-1:DW]);
      SEL_TVAL:   rd_mux = DW'(tv_i);
      SEL_CTRL: begin
        rd_mux[CTL_EN_BIT]   = en_q;
        rd_mux[CTL_MASK_BIT] = mask_q;
        rd_mux[CTL_STAT_BIT] = en_q & cond_i;
      end
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q  <= '0;
      en_q   <= 1'b0;
      mask_q <= 1'b0;
    end else if (accept && req_write) begin
      case (sel)
        SEL_CMP_LO: cmp_q[DW-1:0]    <= req_wdata;
        SEL_CMP_HI: cmp_q[CNT_W-1:DW] <= req_wdata[HI_W-1:0];
        SEL_TVAL:   cmp_q            <= tv_wr_val;
        SEL_CTRL: begin
          en_q   <= req_wdata[CTL_EN_BIT];
          mask_q <= req_wdata[CTL_MASK_BIT];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_v_q <= 1'b0;
      rsp_d_q <= '0;
    end else if (accept && !req_write) begin
      rsp_v_q <= 1'b1;
      rsp_d_q <= rd_mux;
    end else if (rsp_ready) begin
      rsp_v_q <= 1'b0;
    end
  end

  assign cmp_o     = cmp_q;
  assign en_o      = en_q;
  assign mask_o    = mask_q;
  assign rsp_valid = rsp_v_q;
  assign rsp_rdata = rsp_d_q;

  // R9: a stalled response keeps its payload
  p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  // R9: no new request while an untaken response waits
  p_busy_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  // R2: compare moves only on an accepted deadline write
  p_cmp_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready && req_write && (req_addr != 2'd3)) |=> $stable(cmp_o));
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic mask_i,
  input  logic cond_i,
  output logic irq_o
);
  logic irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= en_i & cond_i & ~mask_i;
  end

  assign irq_o = irq_q;

  // R4: interrupt requires enable in the previous cycle
  p_irq_needs_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(en_i));

  // R4: interrupt suppressed after a masked cycle
  p_irq_masked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> !$past(mask_i));

  // R4: interrupt requires the deadline condition in the previous cycle
  p_irq_needs_cond_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(cond_i));
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel #(
  parameter int unsigned CNT_W      = 64,
  parameter int unsigned DW         = 32,
  parameter int unsigned TV_W       = 32,
  parameter bit          HAS_OFFSET = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count_i,
  input  logic [CNT_W-1:0] offset_i,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [1:0]       req_addr,
  input  logic [DW-1:0]    req_wdata,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [DW-1:0]    rsp_rdata,
  output logic             irq_o
);
  logic [CNT_W-1:0] eff, cmp;
  logic             cond, en, mask;
  logic [TV_W-1:0]  tv;

  tmr_match #(.CNT_W(CNT_W), .TV_W(TV_W), .HAS_OFFSET(HAS_OFFSET)) u_match (
    .count_i (count_i),
    .offset_i(offset_i),
    .cmp_i   (cmp),
    .eff_o   (eff),
    .cond_o  (cond),
    .tv_o    (tv)
  );

  tmr_regs #(.CNT_W(CNT_W), .DW(DW), .TV_W(TV_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .req_write(req_write),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata),
    .eff_i    (eff),
    .cond_i   (cond),
    .tv_i     (tv),
    .cmp_o    (cmp),
    .en_o     (en),
    .mask_o   (mask)
  );

  tmr_irq u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .en_i  (en),
    .mask_i(mask),
    .cond_i(cond),
    .irq_o (irq_o)
  );
endmodule

// File: tb/test_tmr_channel.sv
`timescale 1ns/1ps
module test_tmr_channel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] count_i = '0;
  logic [63:0] offset_i = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [1:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_rdata;
  logic        irq_o;

  int checks = 0;
  int fails  = 0;

  logic [63:0] m_cmp = '0;
  logic        m_en = 1'b0, m_mask = 1'b0;

  always #2.5 clk = ~clk;

  tmr_channel i_tmr_channel (
    .clk(clk), .rst_n(rst_n), .count_i(count_i), .offset_i(offset_i),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .irq_o(irq_o)
  );

  function automatic logic [63:0] f_eff();
    return count_i - offset_i;
  endfunction
  function automatic logic f_cond();
    return f_eff() >= m_cmp;
  endfunction
  function automatic logic [31:0] f_ctrl();
    return {29'd0, m_en & f_cond(), m_mask, m_en};
  endfunction
  function automatic logic [31:0] f_tv();
    logic [63:0] d;
    d = m_cmp - f_eff();
    return d[31:0];
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(posedge clk);
    case (a)
      2'd0: m_cmp[31:0]  = d;
      2'd1: m_cmp[63:32] = d;
      2'd2: m_cmp        = f_eff() + {{32{d[31]}}, d};
      default: begin m_en = d[0]; m_mask = d[1]; end
    endcase
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic do_rd(input logic [1:0] a, input string req, input logic [31:0] exp);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    chk({req, " rsp_valid"}, {63'd0, rsp_valid}, 64'd1);
    chk(req, {32'd0, rsp_rdata}, {32'd0, exp});
  endtask

  task automatic chk_irq(input string req);
    @(posedge clk);
    @(negedge clk);
    chk(req, {63'd0, irq_o}, {63'd0, m_en & f_cond() & ~m_mask});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 irq", {63'd0, irq_o}, 64'd0);
    do_rd(2'd3, "R1 ctrl", 32'd0);
    do_rd(2'd0, "R1 cmp lo", 32'd0);
    do_rd(2'd1, "R1 cmp hi", 32'd0);

    // R2: compare halves
    do_wr(2'd0, 32'h0000_1000);
    do_wr(2'd1, 32'h0000_0002);
    do_rd(2'd0, "R2 cmp lo", 32'h0000_1000);
    do_rd(2'd1, "R2 cmp hi", 32'h0000_0002);

    // R3/R4: below, equal, above deadline
    do_wr(2'd3, 32'd1);
    count_i = 64'h0000_0002_0000_0FFF;
    chk_irq("R4 below deadline");
    do_rd(2'd3, "R3 status below", 32'd1);
    count_i = 64'h0000_0002_0000_1000;
    chk_irq("R4 equal fires");
    do_rd(2'd3, "R3 status equal", 32'd5);
    // R4: mask suppresses output, status stays
    do_wr(2'd3, 32'd3);
    chk_irq("R4 masked");
    do_rd(2'd3, "R3 status masked", 32'd7);
    // R8: status and upper bits not writable
    do_wr(2'd3, 32'hFFFF_FFF9);
    do_rd(2'd3, "R8 ctrl readonly bits", 32'd5);
    // R4: new compare clears condition, irq drops next edge
    chk_irq("R4 firing again");
    do_wr(2'd1, 32'h0000_0010);
    chk_irq("R4 drop after compare rewrite");
    chk("R4 dropped", {63'd0, irq_o}, 64'd0);

    // R5/R6: relative write, reads
    do_wr(2'd2, 32'd100);
    do_rd(2'd0, "R5 cmp lo after tv write", m_cmp[31:0]);
    do_rd(2'd1, "R5 cmp hi after tv write", m_cmp[63:32]);
    do_rd(2'd2, "R6 tv read", 32'd100);
    @(negedge clk); count_i = count_i + 64'd30;
    do_rd(2'd2, "R6 tv after 30", 32'd70);
    @(negedge clk); count_i = count_i + 64'd100;
    do_rd(2'd2, "R6 tv negative", 32'hFFFF_FFE2);
    chk_irq("R4 past relative deadline");
    do_wr(2'd2, 32'hFFFF_FFFB);
    do_rd(2'd3, "R5 negative tv fires", 32'd5);

    // R7: offset shifts both views
    do_wr(2'd2, 32'd50);
    @(negedge clk); offset_i = 64'd20;
    do_rd(2'd2, "R7 tv with offset", 32'd70);
    chk_irq("R7 not fired with offset");
    @(negedge clk); count_i = count_i + 64'd60;
    do_rd(2'd2, "R7 tv offset then count", 32'd10);
    @(negedge clk); offset_i = 64'hFFFF_FFFF_FFFF_FFF0;
    chk_irq("R7 offset pushes past deadline");
    do_rd(2'd3, "R7 status with offset", f_ctrl());

    // R9: back-pressure
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 2'd1;
    @(negedge clk);
    chk("R9 rsp valid", {63'd0, rsp_valid}, 64'd1);
    chk("R9 first data", {32'd0, rsp_rdata}, {32'd0, m_cmp[63:32]});
    req_addr = 2'd0;
    repeat (2) begin
      @(negedge clk);
      chk("R9 ready low", {63'd0, req_ready}, 64'd0);
      chk("R9 data held", {32'd0, rsp_rdata}, {32'd0, m_cmp[63:32]});
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 second data", {32'd0, rsp_rdata}, {32'd0, m_cmp[31:0]});
    @(negedge clk);
    chk("R9 drained", {63'd0, rsp_valid}, 64'd0);

    // random mix
    for (int i = 0; i < 400; i++) begin
      int op;
      op = $urandom_range(0, 7);
      @(negedge clk);
      if ($urandom_range(0, 3) == 0) count_i = {$urandom, $urandom};
      else count_i = count_i + 64'($urandom_range(0, 200));
      if ($urandom_range(0, 7) == 0) offset_i = {$urandom, $urandom};
      case (op)
        0: do_wr(2'd0, $urandom);
        1: do_wr(2'd1, $urandom);
        2: do_wr(2'd2, 32'($urandom_range(0, 300)) - 32'd150);
        3: do_wr(2'd3, $urandom);
        4: do_rd(2'd2, "R6 random tv", f_tv());
        5: do_rd(2'd3, "R3 random ctrl", f_ctrl());
        6: do_rd(2'd0, "R2 random cmp lo", m_cmp[31:0]);
        default: do_wr(2'd2, $urandom);
      endcase
      chk_irq("R4 random irq");
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule